// File: doc/BRIEF.md
# Iterative 32x32 Multiplier with Low and High Product Halves

This unit multiplies two 32-bit operands over 32 clock cycles, one bit per cycle. It returns one 32-bit result per operation: the lower half of the product, or the upper half of the product with the operands read as unsigned × unsigned, signed × unsigned or signed × signed. A 6-bit function code chooses the result. An immediate form replaces the second operand with the sign extension of its own low 16 bits and always returns the lower half.

One loop builds both halves in the same pass. The lower half grows MSB-first: the accumulator shifts left, then the multiplicand is added when the top bit of a left-shifting copy of B is set. The unsigned upper half grows LSB-first: the multiplicand is added when the bottom bit of a right-shifting copy of B is set, and the accumulator then shifts right with the carry of that add entering bit 31. The two signed upper-half variants take one more cycle. In that cycle the unsigned upper half is corrected by subtracting B when A is negative and, for signed × signed, also subtracting A when B is negative.

The host places operands and a code on the inputs and pulses `start_i`. It then waits for the one-cycle `done_o` pulse, when `result_o` is valid. Instruction decode and register writeback belong to the surrounding pipeline.

Top module: `mulx_iter_unit`

## Requirements
- R1: With `imm_sel_i`=0 and `func_i`=0x27, the result is bits 31:0 of A×B.
- R2: With `func_i`=0x07, the result is bits 63:32 of the product with A and B both read as unsigned.
- R3: With `func_i`=0x17, the result is bits 63:32 of the product with A read as two's-complement signed and B as unsigned.
- R4: With `func_i`=0x1F, the result is bits 63:32 of the product with both operands read as two's-complement signed.
- R5: Any other `func_i` with bit 1 set (for example 0x02 or 0x3F) gives the signed × signed upper half, as in R4.
- R6: With `imm_sel_i`=1, operand B is the sign extension of `opb_i[15:0]`, `func_i` is ignored, and the result is bits 31:0 of A×B.
- R7: A start with `imm_sel_i`=0 and `func_i` bit 1 clear is ignored: `busy_o` and `done_o` stay 0 and `result_o` keeps its value.
- R8: Count the clock edge that accepts a start as edge 0. `done_o` is high for exactly one cycle, after edge 32 for the lower-half and unsigned upper-half results, and after edge 33 for the two signed upper-half results.
- R9: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start seen while busy is ignored and does not disturb the running result.
- R10: `result_o` keeps the last result after `done_o` until a later operation completes.
- R11: While `rst_n` is low, `busy_o`, `done_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new operation when idle |
| opa_i | input | 32 | Operand A (multiplicand) |
| opb_i | input | 32 | Operand B, or the immediate in bits 15:0 |
| func_i | input | 6 | Function code selecting the result |
| imm_sel_i | input | 1 | Use the sign-extended immediate as B and take the lower half |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: `result_o` is valid |
| result_o | output | 32 | Selected 32-bit result |

## Verification
The bench drives operands 0x80000000, 0xFFFFFFFF, 0x7FFFFFFF, 0 and 1 in every pairing, under every function code. A bad correction cycle gives wrong upper halves only when an operand is negative, and a carry lost from the upper accumulator corrupts bit 31 for large unsigned operands. Immediates with bit 15 set catch zero extension in place of sign extension. Codes with bit 1 clear, and starts issued while busy, catch a unit that launches or reloads when it should not. Latency is measured per operation, so a missing or unconditional correction cycle is seen as a one-cycle error.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  localparam int FUNC_W = 6;
  localparam logic [FUNC_W-1:0] FN_LO = 6'h27;
  localparam logic [FUNC_W-1:0] FN_UU = 6'h07;
  localparam logic [FUNC_W-1:0] FN_SU = 6'h17;
  localparam logic [FUNC_W-1:0] FN_SS = 6'h1F;
  localparam int FN_MUL_BIT = 1;

  typedef enum logic [1:0] {SEL_LO, SEL_UU, SEL_SU, SEL_SS} mulx_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX, ST_FIN} mulx_st_e;
endpackage

// File: rtl/mulx_decode.sv
module mulx_decode
  import mulx_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  input  logic              imm_sel_i,
  output logic              valid_o,
  output mulx_sel_e         sel_o
);
  always_comb begin
    valid_o = imm_sel_i | func_i[FN_MUL_BIT];
    if (imm_sel_i)           sel_o = SEL_LO;
    else if (func_i == FN_LO) sel_o = SEL_LO;
    else if (func_i == FN_UU) sel_o = SEL_UU;
    else if (func_i == FN_SU) sel_o = SEL_SU;
    else                      sel_o = SEL_SS;
  end
endmodule

// File: rtl/mulx_ctrl.sv
module mulx_ctrl
  import mulx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      valid_i,
  input  mulx_sel_e sel_i,
  output mulx_sel_e sel_o,
  output logic      launch_o,
  output logic      step_o,
  output logic      cap_next_o,
  output logic      cap_fix_o,
  output logic      busy_o,
  output logic      done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mulx_st_e        st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  mulx_sel_e       sel_q, sel_n;
  logic            last_step, needs_fix;

  always_comb begin
    launch_o   = (st_q == ST_IDLE) && start_i && valid_i;
    step_o     = (st_q == ST_RUN);
    last_step  = step_o && (cnt_q == LAST);
    needs_fix  = (sel_q == SEL_SU) || (sel_q == SEL_SS);
    cap_next_o = last_step && !needs_fix;
    cap_fix_o  = (st_q == ST_FIX);
    busy_o     = (st_q != ST_IDLE);
    done_o     = (st_q == ST_FIN);
    sel_o      = sel_q;

    st_n  = st_q;
    cnt_n = cnt_q;
    sel_n = sel_q;
    case (st_q)
      ST_IDLE: if (launch_o) begin
        st_n  = ST_RUN;
        cnt_n = '0;
        sel_n = sel_i;
      end
      ST_RUN: begin
        cnt_n = cnt_q + 1'b1;
        if (last_step) st_n = needs_fix ? ST_FIX : ST_FIN;
      end
      ST_FIX:  st_n = ST_FIN;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= SEL_LO;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sel_q <= sel_n;
    end
  end
endmodule

// File: rtl/mulx_datapath.sv
module mulx_datapath
  import mulx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cap_next_i,
  input  logic         cap_fix_i,
  input  mulx_sel_e    sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] a_q, borig_q, bl_q, br_q, lo_q, hi_q, res_q;
  logic [W-1:0] a_n, borig_n, bl_n, br_n, lo_n, hi_n, res_n;
  logic [W-1:0] lo_d, hi_d, fix_a, fix_b;
  logic [W:0]   hi_sum;

  always_comb begin
    lo_d   = (lo_q << 1) + (bl_q[W-1] ? a_q : '0);
    hi_sum = {1'b0, hi_q} + {1'b0, (br_q[0] ? a_q : '0)};
    hi_d   = hi_sum[W:1];
    fix_a  = a_q[W-1] ? borig_q : '0;
    fix_b  = ((sel_i == SEL_SS) && borig_q[W-1]) ? a_q : '0;

    a_n = a_q; borig_n = borig_q; bl_n = bl_q; br_n = br_q;
    lo_n = lo_q; hi_n = hi_q; res_n = res_q;
    if (load_i) begin
      a_n = a_i; borig_n = b_i; bl_n = b_i; br_n = b_i;
      lo_n = '0; hi_n = '0;
    end else if (step_i) begin
      lo_n = lo_d; hi_n = hi_d;
      bl_n = bl_q << 1; br_n = br_q >> 1;
    end
    if (cap_next_i)     res_n = (sel_i == SEL_LO) ? lo_d : hi_d;
    else if (cap_fix_i) res_n = hi_q - fix_a - fix_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; borig_q <= '0; bl_q <= '0; br_q <= '0;
      lo_q <= '0; hi_q <= '0; res_q <= '0;
    end else begin
      a_q <= a_n; borig_q <= borig_n; bl_q <= bl_n; br_q <= br_n;
      lo_q <= lo_n; hi_q <= hi_n; res_q <= res_n;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/mulx_iter_unit.sv
module mulx_iter_unit
  import mulx_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              imm_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      result_o
);
  logic         valid, launch, step, cap_next, cap_fix;
  mulx_sel_e    sel_dec, sel_run;
  logic [W-1:0] b_eff;

  assign b_eff = imm_sel_i ? {{(W-IW){opb_i[IW-1]}}, opb_i[IW-1:0]} : opb_i;

  mulx_decode u_dec (
    .func_i(func_i), .imm_sel_i(imm_sel_i), .valid_o(valid), .sel_o(sel_dec)
  );

  mulx_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid),
    .sel_i(sel_dec), .sel_o(sel_run), .launch_o(launch), .step_o(step),
    .cap_next_o(cap_next), .cap_fix_o(cap_fix), .busy_o(busy_o), .done_o(done_o)
  );

  mulx_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load_i(launch), .step_i(step),
    .cap_next_i(cap_next), .cap_fix_i(cap_fix), .sel_i(sel_run),
    .a_i(opa_i), .b_i(b_eff), .res_o(result_o)
  );
endmodule

// File: rtl/mulx_iter_unit_chk.sv
module mulx_iter_unit_chk #(
  parameter int W  = 32,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [FW-1:0] func_i,
  input logic          imm_sel_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  result_o
);
  logic [$clog2(W+2):0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_cnt == W || busy_cnt == W + 1));

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (imm_sel_i || func_i[1])) |=> (busy_o && !done_o));

  a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !imm_sel_i && !func_i[1]) |=> !busy_o);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(result_o));
endmodule

bind mulx_iter_unit mulx_iter_unit_chk #(.W(W), .FW(mulx_pkg::FUNC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
  .imm_sel_i(imm_sel_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/sim_mulx_iter_unit.sv
module sim_mulx_iter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [5:0]  func = '0;
  logic        imm = 1'b0;
  logic        busy, done;
  logic [31:0] result;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mulx_iter_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opa_i(opa), .opb_i(opb),
    .func_i(func), .imm_sel_i(imm), .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                          input logic [5:0] f, input logic im);
    logic [63:0] p;
    logic [31:0] bb;
    bb = im ? {{16{b[15]}}, b[15:0]} : b;
    if (im || f == 6'h27) begin p = {32'b0, a} * {32'b0, bb}; return p[31:0]; end
    if (f == 6'h07) p = {32'b0, a} * {32'b0, bb};
    else if (f == 6'h17) p = {{32{a[31]}}, a} * {32'b0, bb};
    else p = {{32{a[31]}}, a} * {{32{bb[31]}}, bb};
    return p[63:32];
  endfunction

  function automatic string tag(input logic [5:0] f, input logic im);
    if (im) return "R6 immediate";
    case (f)
      6'h27: return "R1 low";
      6'h07: return "R2 uu-high";
      6'h17: return "R3 su-high";
      6'h1F: return "R4 ss-high";
      default: return "R5 other-code";
    endcase
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f,
                        input logic im, input bit disturb);
    int n;
    int lat;
    logic [31:0] exp;
    exp = ref_res(a, b, f, im);
    lat = (im || f == 6'h27 || f == 6'h07) ? 33 : 34;
    @(negedge clk);
    opa = a; opb = b; func = f; imm = im; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n = 1;
    if (disturb) begin opa = ~a; opb = ~b; func = 6'h27; imm = 1'b0; end
    else start = 1'b0;
    check("R9 busy after accept", {31'b0, busy}, 32'd1);
    while (!done && n < 100) begin @(negedge clk); n++; end
    start = 1'b0;
    check("R8 latency", n, lat);
    check(tag(f, im), result, exp);
    @(negedge clk);
    check("R8 done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] corners [5];
    logic [5:0]  codes [4];
    logic [31:0] held;
    corners[0] = 32'h8000_0000; corners[1] = 32'hFFFF_FFFF; corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'h0; corners[4] = 32'h1;
    codes[0] = 6'h27; codes[1] = 6'h07; codes[2] = 6'h17; codes[3] = 6'h1F;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check("R11 reset busy", {31'b0, busy}, 32'd0);
    check("R11 reset done", {31'b0, done}, 32'd0);
    check("R11 reset result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 4; k++)
          run_op(corners[i], corners[j], codes[k], 1'b0, 1'b0);

    // R5: codes with bit 1 set that are not one of the four named codes
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 6'h02, 1'b0, 1'b0);
    run_op(32'hDEAD_BEEF, 32'h8765_4321, 6'h3F, 1'b0, 1'b0);
    // R6: immediate, func ignored, negative and positive immediates
    run_op(32'h1234_5678, 32'hABCD_8001, 6'h07, 1'b1, 1'b0);
    run_op(32'hFFFF_FFFF, 32'h0000_7FFF, 6'h1F, 1'b1, 1'b0);
    run_op(32'h8000_0000, 32'h5555_FFFF, 6'h00, 1'b1, 1'b0);
    // R9: start held high with other operands while busy
    run_op(32'h8000_0001, 32'hC000_0003, 6'h1F, 1'b0, 1'b1);
    run_op(32'h7654_3210, 32'hFEDC_BA98, 6'h07, 1'b0, 1'b1);

    // R10: result held after done
    held = result;
    repeat (4) @(negedge clk);
    check("R10 result held", result, held);

    // R7: start with bit 1 clear and no immediate is ignored
    opa = 32'h3; opb = 32'h5; func = 6'h24; imm = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R7 busy stays low", {31'b0, busy}, 32'd0);
    repeat (36) begin
      @(negedge clk);
      if (done) check("R7 no done", {31'b0, done}, 32'd0);
    end
    check("R7 result unchanged", result, held);

    for (int r = 0; r < 150; r++) begin
      logic [5:0] f;
      logic im;
      f = codes[$urandom % 4];
      if ($urandom % 8 == 0) f = {$urandom % 64} [5:0] | 6'h02;
      im = ($urandom % 6 == 0);
      run_op($urandom, $urandom, f, im, ($urandom % 10 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule